// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block sits beside a processor whose bus cycles are announced by a three-bit status code. It watches that code on the clock, and when a cycle begins it produces the address-latch strobe. It then drives the one command strobe that fits the cycle: memory read, memory write, I/O read, I/O write or interrupt acknowledge. It also drives the data-transceiver enable and direction. Write cycles get two strobes: an early one and a normal one that follows a configurable number of clocks later. The early strobe serves slow devices that need the write qualifier ahead of time.

Two inputs from the system side shape the outputs. A command-enable input gates all commands and data-enable outputs to their inactive levels without releasing the pins. A bus-release input, asserted by an external arbiter, turns off the output enables of the command pins. Which commands it releases depends on the bus-mode input. In system-bus mode it releases every command. In I/O-bus mode it releases only the memory commands, because the I/O bus is private to the local processor. A shared pin carries either a cascade-enable pulse or an active-low peripheral data enable, selected by the bus mode.

Top module: `bus_cmd_gen`

## Requirements
- R1: The status code (bit 2 first) decodes as follows. 000 is interrupt acknowledge and asserts `int_ack_n`. 001 is I/O read and asserts `io_rd_n`. 010 is I/O write and asserts `io_wr_early_n` and `io_wr_n`. 011 is halt. 100 (fetch) and 101 (memory read) both assert `mem_rd_n`. 110 is memory write and asserts `mem_wr_early_n` and `mem_wr_n`. 111 is passive. At most one kind of command is ever active.
- R2: A cycle starts at a clock edge that samples a non-passive code while the block is idle. For every kind except halt, `addr_strobe` is high for exactly the one clock that follows that edge.
- R3: On the second clock of a cycle, the read strobe, the interrupt-acknowledge strobe or the early write strobe goes low, and `data_en` goes high. Both hold until the cycle is released. Halt is the exception.
- R4: The normal write strobe (`mem_wr_n` or `io_wr_n`) goes low WR_LEAD clocks after its early companion (one clock by default) and stays low until release.
- R5: A clock edge that samples status 111 during a cycle ends it. From the next clock on, all commands are high, `data_en` is low and `dir_out` is high.
- R6: `dir_out` is low from the first clock of a read-type cycle until release. Read-type cycles are fetch, memory read, I/O read and interrupt acknowledge. It is high during write and halt cycles and when idle.
- R7: A halt cycle produces no `addr_strobe`, no command strobe and no `data_en`.
- R8: With `cmd_enable` low, in the same cycle, all seven commands are high, `data_en` is low, and in I/O-bus mode `mce_pden` is high. The command output enables are unchanged, and `addr_strobe` is unaffected.
- R9: In system-bus mode (`io_mode` low), `bus_release` high drives both `mem_cmd_oe` and `io_cmd_oe` low. Otherwise both are high.
- R10: In I/O-bus mode (`io_mode` high), `bus_release` high drives `mem_cmd_oe` low and leaves `io_cmd_oe` high. The I/O strobes and `int_ack_n` stay driven.
- R11: In system-bus mode, `mce_pden` is high only during the `addr_strobe` clock of an interrupt-acknowledge cycle. In I/O-bus mode it is the inverse of `data_en`.
- R12: The cycle kind is latched at the start. A change to another non-passive code before a passive code is sampled has no effect on the outputs.
- R13: While `rst_n` is low at a clock edge, the block returns to idle. In idle all commands are high, `addr_strobe` and `data_en` are low, and `dir_out` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| status | input | 3 | Processor cycle status code |
| bus_release | input | 1 | Arbiter request to release command pins, active high |
| cmd_enable | input | 1 | Command and data-enable gate, active high |
| io_mode | input | 1 | 1 selects I/O-bus mode, 0 selects system-bus mode |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| mem_wr_early_n | output | 1 | Early memory write command, active low |
| io_rd_n | output | 1 | I/O read command, active low |
| io_wr_n | output | 1 | I/O write command, active low |
| io_wr_early_n | output | 1 | Early I/O write command, active low |
| int_ack_n | output | 1 | Interrupt acknowledge command, active low |
| addr_strobe | output | 1 | Address latch strobe, active high |
| data_en | output | 1 | Data transceiver enable, active high |
| dir_out | output | 1 | Transceiver direction, 1 = processor drives data |
| mce_pden | output | 1 | Cascade enable (system mode) or peripheral data enable, active low (I/O mode) |
| mem_cmd_oe | output | 1 | Output enable for the three memory commands |
| io_cmd_oe | output | 1 | Output enable for the I/O commands and interrupt acknowledge |

## Verification
The bench runs every status code through a full cycle under all eight settings of bus release, command enable and bus mode, and compares each clock against an independent model. It targets three errors in particular. A normal write that shares a clock with the early one would collapse the one-clock lead. A bus release that also floats I/O commands in I/O-bus mode would cut a local peripheral off during arbitration. A command enable that floats the pins instead of driving them high would show up as a wrong output enable. Directed tests cover release straight after the address clock, a mid-cycle status change that must be ignored, command enable dropped and restored inside a cycle, and reset in the middle of a write.

// File: rtl/bus_cmd_pkg.sv
// Shared types for the bus command generator.
// Assumes the three-bit status encoding is fixed by the processor.
package bus_cmd_pkg;

    // Cycle progress: idle, address clock, command clocks.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_CMD  = 2'd2
    } phase_t;

    // One decoded bus request; at most one command bit is set.
    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
        logic int_ack;
        logic is_read;
        logic is_halt;
    } cmd_req_t;

    localparam logic [2:0] ST_PASSIVE = 3'b111;

endpackage

// File: rtl/status_decoder.sv
// Translates the processor status code into a request descriptor.
// Pure combinational; the passive code yields an all-zero descriptor.
module status_decoder
    import bus_cmd_pkg::*;
(
    input  logic [2:0] status,
    output cmd_req_t   req
);

    // Map each status code to its command and direction flags.
    always_comb begin
        req = '0;
        case (status)
            3'b000: begin req.int_ack = 1'b1; req.is_read = 1'b1; end
            3'b001: begin req.io_rd   = 1'b1; req.is_read = 1'b1; end
            3'b010: req.io_wr   = 1'b1;
            3'b011: req.is_halt = 1'b1;
            3'b100: begin req.mem_rd  = 1'b1; req.is_read = 1'b1; end
            3'b101: begin req.mem_rd  = 1'b1; req.is_read = 1'b1; end
            3'b110: req.mem_wr  = 1'b1;
            default: req = '0;
        endcase
    end

endmodule

// File: rtl/cycle_sequencer.sv
// Tracks one bus cycle from start to release and latches its kind.
// Assumes status is stable around the rising clock edge; a cycle
// ends only when the passive code is sampled.
module cycle_sequencer
    import bus_cmd_pkg::*;
#(
    parameter int WR_LEAD = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] status,
    input  cmd_req_t   req_d,
    output phase_t     phase,
    output cmd_req_t   req_q,
    output logic       late_wr
);

    localparam int CW = (WR_LEAD > 1) ? $clog2(WR_LEAD) : 1;
    localparam logic [CW-1:0] LEAD_LAST = CW'(WR_LEAD - 1);

    logic          passive;
    logic [CW-1:0] lead_cnt;

    assign passive = (status == ST_PASSIVE);

    // Advance the cycle phase, latch the request, time the late write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            req_q    <= '0;
            late_wr  <= 1'b0;
            lead_cnt <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (!passive) begin
                        phase <= PH_ADDR;
                        req_q <= req_d;
                    end
                end
                PH_ADDR: begin
                    lead_cnt <= '0;
                    late_wr  <= 1'b0;
                    if (passive) begin
                        phase <= PH_IDLE;
                        req_q <= '0;
                    end else begin
                        phase <= PH_CMD;
                    end
                end
                PH_CMD: begin
                    if (passive) begin
                        phase   <= PH_IDLE;
                        req_q   <= '0;
                        late_wr <= 1'b0;
                    end else if (!late_wr) begin
                        if (lead_cnt == LEAD_LAST) late_wr <= 1'b1;
                        else lead_cnt <= lead_cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_ADDR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ADDR) |=> (phase != PH_ADDR)); // R2
    AST_RELEASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE && passive) |=> (phase == PH_IDLE && req_q == '0)); // R5
    AST_KIND_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CMD && !passive) |=> $stable(req_q)); // R12
    AST_LATE_IN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(late_wr) |-> $past(phase == PH_CMD)); // R4

endmodule

// File: rtl/cmd_driver.sv
// Forms the pin-level strobes and enables from the cycle state.
// Command enable gates levels immediately; bus release only touches
// the output enables, split by bus mode.
module cmd_driver
    import bus_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  phase_t   phase,
    input  cmd_req_t req_q,
    input  logic     late_wr,
    input  logic     bus_release,
    input  logic     cmd_enable,
    input  logic     io_mode,
    output logic     mem_rd_n,
    output logic     mem_wr_n,
    output logic     mem_wr_early_n,
    output logic     io_rd_n,
    output logic     io_wr_n,
    output logic     io_wr_early_n,
    output logic     int_ack_n,
    output logic     addr_strobe,
    output logic     data_en,
    output logic     dir_out,
    output logic     mce_pden,
    output logic     mem_cmd_oe,
    output logic     io_cmd_oe
);

    logic cmd_on;
    logic late_on;

    // Gate the latched request into active-low command strobes.
    always_comb begin
        cmd_on         = (phase == PH_CMD) && cmd_enable;
        late_on        = cmd_on && late_wr;
        mem_rd_n       = !(cmd_on  && req_q.mem_rd);
        mem_wr_early_n = !(cmd_on  && req_q.mem_wr);
        mem_wr_n       = !(late_on && req_q.mem_wr);
        io_rd_n        = !(cmd_on  && req_q.io_rd);
        io_wr_early_n  = !(cmd_on  && req_q.io_wr);
        io_wr_n        = !(late_on && req_q.io_wr);
        int_ack_n      = !(cmd_on  && req_q.int_ack);
    end

    // Address strobe, transceiver controls and the shared enable pin.
    always_comb begin
        addr_strobe = (phase == PH_ADDR) && !req_q.is_halt;
        data_en     = cmd_on && !req_q.is_halt;
        dir_out     = !((phase != PH_IDLE) && req_q.is_read);
        if (io_mode) mce_pden = !data_en;
        else         mce_pden = (phase == PH_ADDR) && req_q.int_ack;
    end

    // Output enables: release floats memory always, I/O only in system mode.
    always_comb begin
        mem_cmd_oe = !bus_release;
        io_cmd_oe  = !bus_release || io_mode;
    end

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!mem_rd_n, !mem_wr_early_n, !io_rd_n, !io_wr_early_n, !int_ack_n})); // R1
    AST_CEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_enable |-> (mem_rd_n && mem_wr_n && io_rd_n && io_wr_n && int_ack_n && !data_en)); // R8
    AST_SYS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        (!io_mode && bus_release) |-> (!mem_cmd_oe && !io_cmd_oe)); // R9
    AST_IO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (io_mode && bus_release) |-> (!mem_cmd_oe && io_cmd_oe)); // R10
    AST_LATE_AFTER_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr_n |-> !mem_wr_early_n); // R4

endmodule

// File: rtl/bus_cmd_gen.sv
// Top level: status-decoded bus command generator.
// Assumes a single processor status source; the address latch and
// arbitration live outside. Pin tri-stating is expressed by the two
// output-enable ports.
module bus_cmd_gen
    import bus_cmd_pkg::*;
#(
    parameter int WR_LEAD = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] status,
    input  logic       bus_release,
    input  logic       cmd_enable,
    input  logic       io_mode,
    output logic       mem_rd_n,
    output logic       mem_wr_n,
    output logic       mem_wr_early_n,
    output logic       io_rd_n,
    output logic       io_wr_n,
    output logic       io_wr_early_n,
    output logic       int_ack_n,
    output logic       addr_strobe,
    output logic       data_en,
    output logic       dir_out,
    output logic       mce_pden,
    output logic       mem_cmd_oe,
    output logic       io_cmd_oe
);

    cmd_req_t req_d;
    cmd_req_t req_q;
    phase_t   phase;
    logic     late_wr;

    status_decoder u_dec (
        .status (status),
        .req    (req_d)
    );

    cycle_sequencer #(.WR_LEAD(WR_LEAD)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .status  (status),
        .req_d   (req_d),
        .phase   (phase),
        .req_q   (req_q),
        .late_wr (late_wr)
    );

    cmd_driver u_drv (
        .clk            (clk),
        .rst_n          (rst_n),
        .phase          (phase),
        .req_q          (req_q),
        .late_wr        (late_wr),
        .bus_release    (bus_release),
        .cmd_enable     (cmd_enable),
        .io_mode        (io_mode),
        .mem_rd_n       (mem_rd_n),
        .mem_wr_n       (mem_wr_n),
        .mem_wr_early_n (mem_wr_early_n),
        .io_rd_n        (io_rd_n),
        .io_wr_n        (io_wr_n),
        .io_wr_early_n  (io_wr_early_n),
        .int_ack_n      (int_ack_n),
        .addr_strobe    (addr_strobe),
        .data_en        (data_en),
        .dir_out        (dir_out),
        .mce_pden       (mce_pden),
        .mem_cmd_oe     (mem_cmd_oe),
        .io_cmd_oe      (io_cmd_oe)
    );

endmodule

// File: tb/tb_bus_cmd_gen.sv
// Self-checking bench: table of per-code command flags walked over all
// control settings, then directed corner tests.
module tb_bus_cmd_gen;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    // Per status code: {mem_rd, mem_wr, io_rd, io_wr, int_ack, halt}
    localparam logic [5:0] KIND_TBL [8] = '{
        6'b000010, 6'b001000, 6'b000100, 6'b000001,
        6'b100000, 6'b100000, 6'b010000, 6'b000000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] status = 3'b111;
    logic bus_release = 1'b0;
    logic cmd_enable = 1'b1;
    logic io_mode = 1'b0;
    logic mem_rd_n, mem_wr_n, mem_wr_early_n, io_rd_n, io_wr_n, io_wr_early_n;
    logic int_ack_n, addr_strobe, data_en, dir_out, mce_pden, mem_cmd_oe, io_cmd_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    bus_cmd_gen dut (
        .clk(clk), .rst_n(rst_n), .status(status), .bus_release(bus_release),
        .cmd_enable(cmd_enable), .io_mode(io_mode), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .mem_wr_early_n(mem_wr_early_n), .io_rd_n(io_rd_n),
        .io_wr_n(io_wr_n), .io_wr_early_n(io_wr_early_n), .int_ack_n(int_ack_n),
        .addr_strobe(addr_strobe), .data_en(data_en), .dir_out(dir_out),
        .mce_pden(mce_pden), .mem_cmd_oe(mem_cmd_oe), .io_cmd_oe(io_cmd_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [10:0] actual_vec();
        return {mem_rd_n, mem_wr_n, mem_wr_early_n, io_rd_n, io_wr_n,
                io_wr_early_n, int_ack_n, addr_strobe, data_en, dir_out, mce_pden};
    endfunction

    // Reference model. ph: 0 address clock, 1 first command clock,
    // 2 normal write active, 3 idle.
    function automatic logic [10:0] model(input logic [2:0] code, input int ph,
                                          input logic cen, input logic iob);
        logic [5:0] k;
        logic act, late, rd, ale, den, dir, mp;
        k    = (ph == 3) ? 6'b000000 : KIND_TBL[code];
        act  = (ph == 1 || ph == 2) && cen;
        late = (ph == 2) && cen;
        rd   = k[5] | k[3] | k[1];
        ale  = (ph == 0) && !k[0];
        den  = act && !k[0];
        dir  = !((ph != 3) && rd);
        mp   = iob ? !den : ((ph == 0) && k[1]);
        return {!(act && k[5]), !(late && k[4]), !(act && k[4]), !(act && k[3]),
                !(late && k[2]), !(act && k[2]), !(act && k[1]), ale, den, dir, mp};
    endfunction

    task automatic check_vec(input logic [10:0] exp, input string req);
        checks++;
        if (actual_vec() !== exp) begin
            errors++;
            $display("FAIL %s: outputs=%b expected=%b (status=%b cen=%b iob=%b rel=%b)",
                     req, actual_vec(), exp, status, cmd_enable, io_mode, bus_release);
        end
    endtask

    task automatic check_oe(input logic rel, input logic iob);
        logic [1:0] exp;
        exp = {!rel, !rel || iob};
        checks++;
        if ({mem_cmd_oe, io_cmd_oe} !== exp) begin
            errors++;
            $display("FAIL %s: oe=%b expected=%b", iob ? "R10" : "R9",
                     {mem_cmd_oe, io_cmd_oe}, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R13: reset state.
        tick(); tick();
        check_vec(model(3'b111, 3, 1'b1, 1'b0), "R13");
        rst_n = 1'b1;
        tick();

        // Table walk: every code under every release/enable/mode setting.
        for (int c = 0; c < 7; c++) begin
            for (int m = 0; m < 8; m++) begin
                bus_release = m[0];
                cmd_enable  = m[1];
                io_mode     = m[2];
                tick();
                status = 3'(c);
                tick(); check_vec(model(3'(c), 0, m[1], m[2]), "R1 R2 R6 R7 R11");
                check_oe(m[0], m[2]);
                tick(); check_vec(model(3'(c), 1, m[1], m[2]), "R1 R3 R8");
                tick(); check_vec(model(3'(c), 2, m[1], m[2]), "R4");
                tick(); check_vec(model(3'(c), 2, m[1], m[2]), "R4");
                status = 3'b111;
                tick(); check_vec(model(3'(c), 3, m[1], m[2]), "R5");
            end
        end

        // Passive code never starts a cycle.
        bus_release = 1'b0; cmd_enable = 1'b1; io_mode = 1'b0;
        tick(); tick();
        check_vec(model(3'b111, 3, 1'b1, 1'b0), "R1 passive");

        // R5: release right after the address clock, no command appears.
        status = 3'b110;
        tick(); check_vec(model(3'b110, 0, 1'b1, 1'b0), "R2");
        status = 3'b111;
        tick(); check_vec(model(3'b110, 3, 1'b1, 1'b0), "R5 early release");

        // R12: mid-cycle code change is ignored.
        tick();
        status = 3'b101;
        tick(); tick();
        status = 3'b010;
        tick(); check_vec(model(3'b101, 2, 1'b1, 1'b0), "R12");
        tick(); check_vec(model(3'b101, 2, 1'b1, 1'b0), "R12");
        status = 3'b111;
        tick();

        // R8: command enable dropped and restored inside a write.
        io_mode = 1'b1;
        status = 3'b010;
        tick(); tick(); tick();
        check_vec(model(3'b010, 2, 1'b1, 1'b1), "R4 io write");
        cmd_enable = 1'b0; #1;
        check_vec(model(3'b010, 2, 1'b0, 1'b1), "R8 drop");
        check_oe(1'b0, 1'b1);
        cmd_enable = 1'b1; #1;
        check_vec(model(3'b010, 2, 1'b1, 1'b1), "R8 restore");
        bus_release = 1'b1; #1;
        check_oe(1'b1, 1'b1);
        check_vec(model(3'b010, 2, 1'b1, 1'b1), "R10 io kept");
        bus_release = 1'b0;

        // R13: reset in the middle of a cycle.
        rst_n = 1'b0;
        tick(); check_vec(model(3'b111, 3, 1'b1, 1'b1), "R13 mid-cycle");
        status = 3'b111;
        rst_n = 1'b1;
        tick(); check_vec(model(3'b111, 3, 1'b1, 1'b1), "R13 after");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule